// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This block turns a logical address into a real address by walking two tables held in memory: a segment table found through an address-space designator, then a page table found through the selected segment entry. Run-time configuration inputs choose 24-bit or 31-bit logical addressing, 64 KiB or 1 MiB segments, and 2 KiB or 4 KiB pages. Each request picks either the primary or the secondary designator. The walk reads memory through a port that allows one read in flight at a time.

An eight-entry, fully associative translation cache sits in front of the walk. A hit completes without any memory read. Designators are loaded from a 16-entry table indexed by an address space number. Any designator load empties the cache.

Each request finishes with a one-cycle done pulse that carries a 3-bit fault code, the real address and a read-only flag.

Top module: `seg_page_xlate`

## Requirements
- R1: The effective address is `req_va` when `cfg_wide`=1, and only `req_va[23:0]` when `cfg_wide`=0. The segment index is the effective address shifted right by 20 when `cfg_seg1m`=1, or by 16 when it is 0. The page index is the offset within the segment shifted right by 12 when `cfg_pg4k`=1, or by 11 when it is 0. The byte offset is the bits below the page shift.
- R2: A designator is 48 bits: bits [47:16] hold the segment table byte origin and bits [15:0] hold the highest valid segment index. A larger segment index ends the request with fault 1 and performs no memory read.
- R3: A segment entry is the word at origin + 4*segment index. Its fields are: bits [31:12] the page table origin (4 KiB aligned), [11:3] the highest page index, [2] common, [1] protect and [0] invalid. If invalid is set, the request ends with fault 2 after one read.
- R4: A page index above the entry's highest page index ends the request with fault 3 after one read.
- R5: A page entry is the word at page-table origin + 4*page index. Bits [31:11] hold the frame and bit [0] is invalid. If invalid is set, the request ends with fault 4. Otherwise the real address is the frame bits above the page shift joined with the byte offset.
- R6: A write into a segment whose protect bit is set ends with fault 5, whether the translation came from the walk or from the cache. A read of that segment succeeds with `rsp_ro`=1.
- R7: `rsp_done` lasts one cycle for each accepted request. A fault code other than 0 comes with `rsp_raddr`=0 and `rsp_ro`=0. No fault code above 5 is produced.
- R8: A successful walk fills the cache. A later request to the same page, under the same configuration and address space, completes with no memory read and gives the same real address for the new offset.
- R9: `req_sec`=1 translates through the secondary designator and `req_sec`=0 through the primary. A cached translation from one space does not serve the other unless its segment is common.
- R10: `ld_valid` copies table entry `ld_asn[3:0]` into the primary designator (`ld_sec`=0) or the secondary designator (`ld_sec`=1), and flushes the whole cache.
- R11: A cache entry filled from a segment whose common bit is set matches requests through either designator.
- R12: `mem_req` stays high with `mem_addr` unchanged until `mem_ack`. While a walk is in progress, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1: 31-bit logical addresses, 0: 24-bit |
| cfg_seg1m | input | 1 | 1: 1 MiB segments, 0: 64 KiB |
| cfg_pg4k | input | 1 | 1: 4 KiB pages, 0: 2 KiB |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_va | input | 31 | Logical address |
| req_write | input | 1 | Request is a write |
| req_sec | input | 1 | Use secondary designator |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 3 | 0 none, 1 seg length, 2 seg invalid, 3 page length, 4 page invalid, 5 protection |
| rsp_raddr | output | 32 | Real address, 0 on fault |
| rsp_ro | output | 1 | Segment read-only |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table word byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tbl_we | input | 1 | Write address-space table entry |
| tbl_idx | input | 4 | Table entry index |
| tbl_dsg | input | 48 | Designator to store |
| ld_valid | input | 1 | Load a designator from the table |
| ld_sec | input | 1 | 1: load secondary, 0: load primary |
| ld_asn | input | 16 | Address space number, low 4 bits index the table |

## Verification
The hardest case to reach from the ports is a cache hit that should not happen. A page cached under one address space must miss under the other, and a common-segment entry must hit there. The stimulus sets this up with the secondary designator's length too short to reach the common segment. A correct hit is therefore the only way that request can succeed without a segment-length fault. The hit path for protection is reached by first caching a read of a protected page and then writing to it. Every request is also checked against a count of memory reads, which separates hits, early faults and full walks.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int VA_W  = 31;
  localparam int RA_W  = 32;
  localparam int SIX_W = 16;
  localparam int PIX_W = 9;
  localparam int OFF_W = 12;
  localparam int KEY_W = 23;
  localparam int FRM_W = 21;

  typedef enum logic [2:0] {
    F_NONE    = 3'd0,
    F_SEG_LEN = 3'd1,
    F_SEG_INV = 3'd2,
    F_PG_LEN  = 3'd3,
    F_PG_INV  = 3'd4,
    F_PROT    = 3'd5
  } fault_e;

  typedef struct packed {
    logic [31:0] org;
    logic [15:0] lim;
  } dsg_t;

  typedef enum logic [1:0] {S_IDLE, S_SEG, S_PAGE} st_e;
endpackage

// File: rtl/xlt_split.sv
module xlt_split
  import xlt_pkg::*;
(
  input  logic [VA_W-1:0]  va,
  input  logic             wide,
  input  logic             seg_big,
  input  logic             pg_big,
  output logic [SIX_W-1:0] seg_idx,
  output logic [PIX_W-1:0] pg_idx,
  output logic [OFF_W-1:0] off,
  output logic [KEY_W-1:0] key
);
  logic [VA_W-1:0] eff;
  logic [19:0]     inseg;

  always_comb begin
    eff     = wide ? va : {7'b0, va[23:0]};
    seg_idx = seg_big ? {5'b0, eff[30:20]} : {1'b0, eff[30:16]};
    inseg   = seg_big ? eff[19:0] : {4'b0, eff[15:0]};
    pg_idx  = pg_big ? {1'b0, inseg[19:12]} : inseg[19:11];
    off     = pg_big ? eff[11:0] : {1'b0, eff[10:0]};
    key     = {wide, seg_big, pg_big, eff[30:12], eff[11] & ~pg_big};
  end
endmodule

// File: rtl/xlt_asn.sv
module xlt_asn
  import xlt_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  dsg_t          tbl_dsg,
  input  logic          ld_valid,
  input  logic          ld_sec,
  input  logic [IW-1:0] ld_idx,
  output dsg_t          prim,
  output dsg_t          scnd
);
  dsg_t tbl_q [N];
  dsg_t prim_q, prim_d, scnd_q, scnd_d;

  always_ff @(posedge clk) begin
    if (tbl_we) tbl_q[tbl_idx] <= tbl_dsg;
  end

  always_comb begin
    prim_d = prim_q;
    scnd_d = scnd_q;
    if (ld_valid && !ld_sec) prim_d = tbl_q[ld_idx];
    if (ld_valid &&  ld_sec) scnd_d = tbl_q[ld_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
      scnd_q <= '0;
    end else begin
      prim_q <= prim_d;
      scnd_q <= scnd_d;
    end
  end

  assign prim = prim_q;
  assign scnd = scnd_q;
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter int N = 8,
  localparam int PW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [KEY_W-1:0] lk_key,
  input  logic             lk_sec,
  output logic             hit,
  output logic [FRM_W-1:0] hit_frame,
  output logic             hit_ro,
  input  logic             fill,
  input  logic [KEY_W-1:0] f_key,
  input  logic             f_sec,
  input  logic             f_com,
  input  logic [FRM_W-1:0] f_frame,
  input  logic             f_ro
);
  logic [N-1:0]     vld_q, vld_d, match;
  logic [KEY_W-1:0] key_q [N];
  logic [FRM_W-1:0] frm_q [N];
  logic [N-1:0]     sec_q, com_q, ro_q;
  logic [PW-1:0]    rr_q, rr_d;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (key_q[g] == lk_key) &&
                      (com_q[g] || (sec_q[g] == lk_sec));
  end

  always_comb begin
    hit       = |match;
    hit_frame = '0;
    hit_ro    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_frame = frm_q[i];
        hit_ro    = ro_q[i];
      end
    end
    vld_d = vld_q;
    rr_d  = rr_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill) begin
      vld_d[rr_q] = 1'b1;
      rr_d        = rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      key_q[rr_q] <= f_key;
      frm_q[rr_q] <= f_frame;
      sec_q[rr_q] <= f_sec;
      com_q[rr_q] <= f_com;
      ro_q[rr_q]  <= f_ro;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlt_pkg::*;
#(
  parameter int TLB_N = 8,
  parameter int ASN_N = 16,
  localparam int AIW = $clog2(ASN_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_seg1m,
  input  logic              cfg_pg4k,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic              req_sec,
  output logic              rsp_done,
  output logic [2:0]        rsp_fault,
  output logic [RA_W-1:0]   rsp_raddr,
  output logic              rsp_ro,
  output logic              mem_req,
  output logic [RA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              tbl_we,
  input  logic [AIW-1:0]    tbl_idx,
  input  logic [47:0]       tbl_dsg,
  input  logic              ld_valid,
  input  logic              ld_sec,
  input  logic [15:0]       ld_asn
);
  logic [1:0] rs_q;
  logic       rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  dsg_t prim, scnd, dsg;
  logic [SIX_W-1:0] seg_idx;
  logic [PIX_W-1:0] pg_idx;
  logic [OFF_W-1:0] off;
  logic [KEY_W-1:0] key;
  logic             hit, hit_ro, fill;
  logic [FRM_W-1:0] hit_frame, fill_frame;

  xlt_asn #(.N(ASN_N)) u_asn (
    .clk(clk), .rst_n(rs_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_dsg(dsg_t'(tbl_dsg)), .ld_valid(ld_valid), .ld_sec(ld_sec),
    .ld_idx(ld_asn[AIW-1:0]), .prim(prim), .scnd(scnd)
  );

  xlt_split u_split (
    .va(req_va), .wide(cfg_wide), .seg_big(cfg_seg1m), .pg_big(cfg_pg4k),
    .seg_idx(seg_idx), .pg_idx(pg_idx), .off(off), .key(key)
  );

  st_e              st_q, st_d;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic             wr_q, wr_d, sec_q, sec_d, pg4k_q, pg4k_d;
  logic             stale_q, stale_d, ro_q, ro_d, com_q, com_d;
  logic [RA_W-1:0]  maddr_q, maddr_d, raddr_q, raddr_d;
  logic             done_q, done_d, rro_q, rro_d;
  fault_e           flt_q, flt_d;

  xlt_tlb #(.N(TLB_N)) u_tlb (
    .clk(clk), .rst_n(rs_n), .flush(ld_valid),
    .lk_key(key), .lk_sec(req_sec), .hit(hit), .hit_frame(hit_frame), .hit_ro(hit_ro),
    .fill(fill), .f_key(key_q), .f_sec(sec_q), .f_com(com_q),
    .f_frame(fill_frame), .f_ro(ro_q)
  );

  assign dsg        = req_sec ? scnd : prim;
  assign fill_frame = {mem_rdata[31:12], mem_rdata[11] & ~pg4k_q};

  always_comb begin
    st_d    = st_q;    pix_d  = pix_q;  off_d  = off_q;  key_d  = key_q;
    wr_d    = wr_q;    sec_d  = sec_q;  pg4k_d = pg4k_q; ro_d   = ro_q;
    com_d   = com_q;   maddr_d = maddr_q;
    raddr_d = raddr_q; rro_d  = rro_q;  flt_d  = flt_q;
    done_d  = 1'b0;    fill   = 1'b0;
    stale_d = (st_q == S_IDLE) ? ld_valid : (stale_q | ld_valid);
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        pix_d = pg_idx; off_d = off; key_d = key; wr_d = req_write;
        sec_d = req_sec; pg4k_d = cfg_pg4k;
        if (hit) begin
          done_d  = 1'b1;
          flt_d   = (req_write && hit_ro) ? F_PROT : F_NONE;
          raddr_d = (req_write && hit_ro) ? '0 :
                    (cfg_pg4k ? {hit_frame[FRM_W-1:1], off} : {hit_frame, off[10:0]});
          rro_d   = hit_ro && !req_write;
        end else if (seg_idx > dsg.lim) begin
          done_d = 1'b1; flt_d = F_SEG_LEN; raddr_d = '0; rro_d = 1'b0;
        end else begin
          maddr_d = dsg.org + {14'b0, seg_idx, 2'b00};
          st_d    = S_SEG;
        end
      end
      S_SEG: if (mem_ack) begin
        if (mem_rdata[0] || (pix_q > mem_rdata[11:3])) begin
          done_d  = 1'b1; raddr_d = '0; rro_d = 1'b0; st_d = S_IDLE;
          flt_d   = mem_rdata[0] ? F_SEG_INV : F_PG_LEN;
        end else begin
          ro_d    = mem_rdata[1];
          com_d   = mem_rdata[2];
          maddr_d = {mem_rdata[31:12], 12'b0} + {21'b0, pix_q, 2'b00};
          st_d    = S_PAGE;
        end
      end
      S_PAGE: if (mem_ack) begin
        done_d = 1'b1;
        st_d   = S_IDLE;
        if (mem_rdata[0] || (wr_q && ro_q)) begin
          flt_d = mem_rdata[0] ? F_PG_INV : F_PROT;
          raddr_d = '0; rro_d = 1'b0;
        end else begin
          flt_d   = F_NONE;
          raddr_d = pg4k_q ? {mem_rdata[31:12], off_q} : {mem_rdata[31:11], off_q[10:0]};
          rro_d   = ro_q;
          fill    = !stale_q && !ld_valid;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q <= S_IDLE; done_q <= 1'b0; flt_q <= F_NONE; raddr_q <= '0; rro_q <= 1'b0;
      stale_q <= 1'b0; maddr_q <= '0; pix_q <= '0; off_q <= '0; key_q <= '0;
      wr_q <= 1'b0; sec_q <= 1'b0; pg4k_q <= 1'b0; ro_q <= 1'b0; com_q <= 1'b0;
    end else begin
      st_q <= st_d; done_q <= done_d; flt_q <= flt_d; raddr_q <= raddr_d; rro_q <= rro_d;
      stale_q <= stale_d; maddr_q <= maddr_d; pix_q <= pix_d; off_q <= off_d; key_q <= key_d;
      wr_q <= wr_d; sec_q <= sec_d; pg4k_q <= pg4k_d; ro_q <= ro_d; com_q <= com_d;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign mem_req   = (st_q != S_IDLE);
  assign mem_addr  = maddr_q;
  assign rsp_done  = done_q;
  assign rsp_fault = flt_q;
  assign rsp_raddr = raddr_q;
  assign rsp_ro    = rro_q;
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_done,
  input logic [2:0]  rsp_fault,
  input logic [31:0] rsp_raddr,
  input logic        rsp_ro,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        wr_q
);
  p_fault_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault != 3'd0) |-> (rsp_raddr == 32'd0 && !rsp_ro));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_fault <= 3'd5);

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_no_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault == 3'd0) |-> !(wr_q && rsp_ro));
endmodule

bind seg_page_xlate xlt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .rsp_fault(rsp_fault), .rsp_raddr(rsp_raddr), .rsp_ro(rsp_ro),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .wr_q(wr_q)
);

// File: tb/seg_page_xlate_tb_top.sv
module seg_page_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wide, cfg_seg1m, cfg_pg4k;
  logic        req_valid, req_ready, req_write, req_sec;
  logic [30:0] req_va;
  logic        rsp_done, rsp_ro;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_raddr;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        tbl_we, ld_valid, ld_sec;
  logic [3:0]  tbl_idx;
  logic [47:0] tbl_dsg;
  logic [15:0] ld_asn;

  int checks = 0, errors = 0, reads = 0, lat = 0, hold_err = 0;
  logic [31:0] mem [4096];
  logic [31:0] last_addr;
  logic        pend;

  always #5 clk = ~clk;

  seg_page_xlate dut_i (.*);

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (pend && mem_req && mem_addr != last_addr) hold_err <= hold_err + 1;
    pend      <= mem_req && !mem_ack;
    last_addr <= mem_addr;
    if (mem_req && !mem_ack) begin
      if (lat == 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[13:2]];
        reads     <= reads + 1;
        lat       <= 0;
      end else lat <= lat + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] ste(input logic [31:0] pt, input int lim,
                                      input bit com, input bit prot, input bit inv);
    return {pt[31:12], lim[8:0], com, prot, inv};
  endfunction

  task automatic xlate(input string tag, input logic [30:0] va, input bit wr, input bit sec,
                       input logic [2:0] ef, input logic [31:0] ea, input bit ero, input int erd);
    int r0;
    bit got;
    got = 1'b0;
    @(negedge clk);
    r0 = reads;
    req_valid = 1'b1; req_va = va; req_write = wr; req_sec = sec;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 60 && !got; i++) begin
      if (rsp_done) got = 1'b1; else @(negedge clk);
    end
    chk(got, {tag, " done seen"}, {31'b0, got}, 32'd1);
    chk(rsp_fault == ef, {tag, " fault"}, {29'b0, rsp_fault}, {29'b0, ef});
    chk(rsp_raddr == ea, {tag, " raddr"}, rsp_raddr, ea);
    chk(rsp_ro == ero, {tag, " ro"}, {31'b0, rsp_ro}, {31'b0, ero});
    chk(reads - r0 == erd, {tag, " reads"}, reads - r0, erd);
    @(negedge clk);
    chk(!rsp_done, {tag, " R7 single pulse"}, {31'b0, rsp_done}, 32'd0);
  endtask

  task automatic load(input bit sec, input logic [15:0] asn);
    @(negedge clk);
    ld_valid = 1'b1; ld_sec = sec; ld_asn = asn;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic put(input int idx, input logic [47:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx[3:0]; tbl_dsg = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready, "reset ready", {31'b0, req_ready}, 32'd1);
    chk(!rsp_done, "reset done", {31'b0, rsp_done}, 32'd0);
    chk(!mem_req, "reset R12 mem_req", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_faults;
    xlate("R5 page invalid", 31'h000810, 0, 0, 3'd4, 0, 0, 2);
    xlate("R3 seg invalid", 31'h010000, 0, 0, 3'd2, 0, 0, 1);
    xlate("R2 seg length", 31'h040000, 0, 0, 3'd1, 0, 0, 0);
    xlate("R4 page length", 31'h021000, 0, 0, 3'd3, 0, 0, 1);
  endtask

  task automatic t_protect;
    xlate("R6 write walk", 31'h020004, 1, 0, 3'd5, 0, 0, 2);
    xlate("R6 read ro", 31'h020004, 0, 0, 3'd0, 32'h00555004, 1, 2);
    xlate("R6 write hit", 31'h020008, 1, 0, 3'd5, 0, 0, 0);
  endtask

  task automatic t_modes;
    xlate("R1 narrow masks high", 31'h7F000123, 0, 0, 3'd0, 32'h00ABC923, 0, 0);
    cfg_wide = 1'b1;
    xlate("R1 wide seg length", 31'h7F000123, 0, 0, 3'd1, 0, 0, 0);
    cfg_wide = 1'b0; cfg_pg4k = 1'b1;
    xlate("R1 4k page", 31'h002010, 0, 0, 3'd0, 32'h00123010, 0, 2);
    xlate("R1 4k invalid", 31'h001010, 0, 0, 3'd4, 0, 0, 2);
    cfg_pg4k = 1'b0; cfg_seg1m = 1'b1;
    xlate("R1 1m page length", 31'h010000, 0, 0, 3'd3, 0, 0, 1);
    xlate("R1 1m page", 31'h001010, 0, 0, 3'd0, 32'h00123010, 0, 2);
    cfg_seg1m = 1'b0;
  endtask

  task automatic t_spaces;
    xlate("R9 secondary", 31'h000123, 0, 1, 3'd0, 32'h00555123, 0, 2);
    xlate("R11 common fill", 31'h030800, 0, 0, 3'd0, 32'h00666800, 0, 2);
    xlate("R11 common hit other space", 31'h030810, 0, 1, 3'd0, 32'h00666810, 0, 0);
    xlate("R9 primary kept", 31'h000124, 0, 0, 3'd0, 32'h00ABC924, 0, 0);
  endtask

  task automatic t_flush;
    load(1'b0, 16'h0001);
    xlate("R10 flush refetch", 31'h000123, 0, 0, 3'd0, 32'h00ABC923, 0, 2);
    load(1'b1, 16'hFF02);
    xlate("R10 asn load secondary", 31'h000123, 0, 1, 3'd0, 32'h00ABC923, 0, 2);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wide = 0; cfg_seg1m = 0; cfg_pg4k = 0;
    req_valid = 0; req_va = '0; req_write = 0; req_sec = 0;
    tbl_we = 0; tbl_idx = '0; tbl_dsg = '0; ld_valid = 0; ld_sec = 0; ld_asn = '0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h1;
    mem['h1000 >> 2] = ste(32'h2000, 15, 0, 0, 0);
    mem['h1004 >> 2] = ste(32'h0, 0, 0, 0, 1);
    mem['h1008 >> 2] = ste(32'h3000, 1, 0, 1, 0);
    mem['h100C >> 2] = ste(32'h3000, 1, 1, 0, 0);
    mem['h1800 >> 2] = ste(32'h3000, 1, 0, 0, 0);
    mem['h1804 >> 2] = ste(32'h2000, 15, 0, 0, 0);
    mem['h2000 >> 2] = 32'h00ABC800;
    mem['h2004 >> 2] = 32'h00000001;
    mem['h2008 >> 2] = 32'h00123000;
    mem['h3000 >> 2] = 32'h00555000;
    mem['h3004 >> 2] = 32'h00666800;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    put(1, {32'h1000, 16'd3});
    put(5, {32'h1800, 16'd1});
    put(2, {32'h1000, 16'd3});
    load(1'b0, 16'h0001);
    load(1'b1, 16'h0005);
    xlate("R1 R5 basic walk", 31'h000123, 0, 0, 3'd0, 32'h00ABC923, 0, 2);
    xlate("R8 hit", 31'h0007FF, 0, 0, 3'd0, 32'h00ABCFFF, 0, 0);
    xlate("R5 page two", 31'h001010, 0, 0, 3'd0, 32'h00123010, 0, 2);
    t_faults;
    t_protect;
    t_modes;
    t_spaces;
    t_flush;
    chk(hold_err == 0, "R12 address held", hold_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule